// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two 32-bit integers one bit at a time and returns the full 64-bit product. A single 32-bit adder serves every step. One 64-bit register holds both the growing partial product in its upper half and the multiplier bits still to be consumed in its lower half. Each clock cycle, bit 0 of that register decides whether the multiplicand is added to the upper half. The whole register then moves one place right, and the adder's carry enters at the top.

A mode input selects unsigned or two's-complement operation. In signed mode, the sign of the result is the XOR of the two operand signs. Both operands are reduced to magnitudes, and the run covers only the 31 non-sign bits of the multiplier. The magnitude is then negated when the sign is negative. One exception applies: when the multiplier is the most negative value, its magnitude is 2^31. That bit would be skipped, so the run extends to 32 steps. A one-cycle start request launches an operation while the block is idle. Busy stays high for the whole run, and a one-cycle done pulse marks a new product on the output.

Top module: `seqmul`

## Requirements
- R1: After reset, busy, done and the product output are all 0.
- R2: When start is high on a clock edge while busy is low, the operands and mode are captured, and busy is high from that edge until the edge that raises done.
- R3: In unsigned mode (signed_i = 0), the product equals a_i × b_i as a 64-bit unsigned number, and done rises exactly 33 edges after the capture edge.
- R4: In signed mode (signed_i = 1), the operands and the product are two's complement, and the product equals a_i × b_i. When b_i is not 0x80000000, done rises exactly 32 edges after the capture edge.
- R5: In signed mode with b_i = 0x80000000, the product is still exact: 0x80000000 × 0x80000000 gives 0x4000000000000000. Done rises 33 edges after the capture edge.
- R6: The adder's carry is never lost. For example, 0xFFFFFFFF × 0xFFFFFFFF unsigned gives 0xFFFFFFFE00000001.
- R7: Done is a single-cycle pulse, and it is high only in the cycle right after busy falls.
- R8: A start request while busy has no effect. The running operation's product and latency are unchanged.
- R9: The product output changes only on the edge that raises done, and it holds its value until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new multiply; honoured only while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: product_o just updated |
| product_o | output | 64 | 64-bit product of the last finished operation |

## Verification
The product is due 33 edges after the capture edge in unsigned mode. In signed mode it is due after 32 edges, or after 33 when the multiplier is the most negative value. The bench releases start at the falling edge after capture. It then counts rising edges, looking at done only at falling edges, and compares that count with the mode-dependent figure. It checks the product in that same cycle against a reference product, computed with 64-bit arithmetic from the requirements. A start pulse injected in the middle of a run must leave both the count and the product unchanged.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } seqmul_state_e;
endpackage

// File: rtl/seqmul_operand_prep.sv
module seqmul_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         signed_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_o,
  output logic         short_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  // Magnitude of a value; in signed mode the most negative input maps to 2^(W-1).
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sg);
    if (sg && v[W-1]) magnitude = ~v + {{(W-1){1'b0}}, 1'b1};
    else              magnitude = v;
  endfunction

  always_comb begin
    mag_a_o = magnitude(a_i, signed_i);
    mag_b_o = magnitude(b_i, signed_i);
    neg_o   = signed_i && (a_i[W-1] ^ b_i[W-1]);
    // Skip the sign position unless the multiplier magnitude actually uses it.
    short_o = signed_i && (b_i != MIN_NEG);
  end
endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic short_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic short_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL_RUN  = CW'(W);
  localparam logic [CW-1:0] SHORT_RUN = CW'(W - 1);

  seqmul_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] iters_q;
  logic          short_q;
  logic          last_step;

  assign busy_o    = (state_q != ST_IDLE);
  assign load_o    = start_i && (state_q == ST_IDLE);
  assign step_o    = (state_q == ST_RUN);
  assign fix_o     = (state_q == ST_FIX);
  assign short_o   = short_q;
  assign last_step = (cnt_q == iters_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      iters_q <= FULL_RUN;
      short_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          iters_q <= short_i ? SHORT_RUN : FULL_RUN;
          short_q <= short_i;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (last_step) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R3 R4 R5
  iteration_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_o |-> (cnt_q == iters_q));

  // R8
  run_length_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(iters_q));
endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [W:0]     add_sum;
  logic [2*W-1:0] prod_next;

  // One iteration: conditional add into the upper half, carry kept as bit W.
  function automatic logic [W:0] add_upper(input logic [W-1:0] hi, input logic [W-1:0] m,
                                           input logic take);
    add_upper = {1'b0, hi} + (take ? {1'b0, m} : {(W+1){1'b0}});
  endfunction

  assign add_sum   = add_upper(prod_q[2*W-1:W], mcand_q, prod_q[0]);
  assign prod_next = {add_sum, prod_q[W-1:1]};
  assign prod_o    = prod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q  <= prod_next;
    end
  end

  // R8
  mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mcand_q));

  // R6
  skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !prod_q[0]) |=> (prod_q[2*W-1] == 1'b0));
endmodule

// File: rtl/seqmul_finish.sv
module seqmul_finish #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           neg_i,
  input  logic           fix_i,
  input  logic           short_i,
  input  logic [2*W-1:0] prod_i,
  output logic           done_o,
  output logic [2*W-1:0] result_o
);
  logic           neg_q;
  logic [2*W-1:0] mag;
  logic [2*W-1:0] signed_res;

  // A shortened run leaves the product one place to the left of its final position.
  function automatic logic [2*W-1:0] align(input logic [2*W-1:0] p, input logic sh);
    align = sh ? {1'b0, p[2*W-1:1]} : p;
  endfunction

  function automatic logic [2*W-1:0] apply_sign(input logic [2*W-1:0] m, input logic n);
    apply_sign = n ? (~m + {{(2*W-1){1'b0}}, 1'b1}) : m;
  endfunction

  assign mag        = align(prod_i, short_i);
  assign signed_res = apply_sign(mag, neg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q    <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= fix_i;
      if (load_i) neg_q <= neg_i;
      if (fix_i) result_o <= signed_res;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

// File: rtl/seqmul.sv
module seqmul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  logic [W-1:0]   mag_a;
  logic [W-1:0]   mag_b;
  logic           neg_in;
  logic           short_in;
  logic           load;
  logic           step;
  logic           fix;
  logic           short_run;
  logic [2*W-1:0] prod_reg;

  seqmul_operand_prep #(.W(W)) prep_i (
    .a_i(a_i), .b_i(b_i), .signed_i(signed_i),
    .mag_a_o(mag_a), .mag_b_o(mag_b), .neg_o(neg_in), .short_o(short_in)
  );

  seqmul_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_i(short_in),
    .busy_o(busy_o), .load_o(load), .step_o(step), .fix_o(fix), .short_o(short_run)
  );

  seqmul_datapath #(.W(W)) dp_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
    .mcand_i(mag_a), .mplier_i(mag_b), .prod_o(prod_reg)
  );

  seqmul_finish #(.W(W)) fin_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .neg_i(neg_in), .fix_i(fix),
    .short_i(short_run), .prod_i(prod_reg), .done_o(done_o), .result_o(product_o)
  );

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/seqmul_tb_top.sv
module seqmul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        busy_o;
  logic        done_o;
  logic [63:0] product_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seqmul dut_i (.*);

  function automatic logic [63:0] ref_product(input logic [31:0] a, input logic [31:0] b,
                                              input bit sg);
    longint sa, sb;
    if (sg) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ref_product = 64'(sa * sb);
    end else begin
      ref_product = {32'h0, a} * {32'h0, b};
    end
  endfunction

  function automatic int ref_latency(input logic [31:0] b, input bit sg);
    if (!sg) ref_latency = 33;
    else if (b == 32'h8000_0000) ref_latency = 33;
    else ref_latency = 32;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Drive one operation; optionally inject a start with other operands mid-run.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit sg,
                        input string req, input bit inject);
    logic [63:0] exp_p;
    int exp_lat;
    int cyc;
    exp_p   = ref_product(a, b, sg);
    exp_lat = ref_latency(b, sg);
    @(negedge clk);
    a_i = a; b_i = b; signed_i = sg; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    a_i = ~a; b_i = b ^ 32'h5A5A_0F0F; signed_i = ~sg;
    check(busy_o === 1'b1, "R2 busy after capture", {63'b0, busy_o}, 64'd1);
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (inject && cyc == 5) start_i = 1'b1;
      if (inject && cyc == 6) start_i = 1'b0;
      if (done_o || cyc > 40) break;
      if (cyc > 1 && busy_o !== 1'b1)
        check(1'b0, "R2 busy held", {63'b0, busy_o}, 64'd1);
    end
    start_i = 1'b0;
    check(cyc == exp_lat, {req, " latency"}, 64'(cyc), 64'(exp_lat));
    check(product_o === exp_p, {req, " product"}, product_o, exp_p);
    check(busy_o === 1'b0, "R7 busy low with done", {63'b0, busy_o}, 64'd0);
    @(negedge clk);
    check(done_o === 1'b0, "R7 done single cycle", {63'b0, done_o}, 64'd0);
    check(product_o === exp_p, "R9 product held", product_o, exp_p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] ra, rb;
    bit rs;
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0, "R1 busy in reset", {63'b0, busy_o}, 64'd0);
    check(done_o === 1'b0, "R1 done in reset", {63'b0, done_o}, 64'd0);
    check(product_o === 64'd0, "R1 product in reset", product_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && product_o === 64'd0,
          "R1 idle after reset", product_o, 64'd0);

    // Directed corner cases
    run_op(32'd3, 32'd2, 1'b0, "R3 small unsigned", 1'b0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R6 all ones carry", 1'b0);
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 top bits unsigned", 1'b0);
    run_op(32'd0, 32'hDEAD_BEEF, 1'b0, "R3 zero operand", 1'b0);
    run_op(32'hFFFF_FFFF, 32'd7, 1'b1, "R4 minus one times seven", 1'b0);
    run_op(32'hFFFF_FFF9, 32'hFFFF_FFFD, 1'b1, "R4 two negatives", 1'b0);
    run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R4 max positive squared", 1'b0);
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R4 min times max", 1'b0);
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R5 min times min", 1'b0);
    run_op(32'd5, 32'h8000_0000, 1'b1, "R5 five times min", 1'b0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R4 min times minus one", 1'b0);
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R8 start ignored unsigned", 1'b1);
    run_op(32'hFEDC_BA98, 32'h0765_4321, 1'b1, "R8 start ignored signed", 1'b1);

    // Constrained random
    for (int i = 0; i < 60; i++) begin
      ra = $urandom();
      rb = $urandom();
      rs = 1'($urandom_range(0, 1));
      if (i % 10 == 3) rb = 32'h8000_0000;
      if (i % 10 == 7) ra = {16'hFFFF, ra[15:0]};
      run_op(ra, rb, rs, rs ? "R4 random signed" : "R3 random unsigned", (i % 8) == 5);
    end
    finish_run();
  end
endmodule